// File: doc/BRIEF.md
# Paged Nibble Accumulator Processor

This block is a very small 4-bit accumulator processor. It executes one-byte instructions taken from a 256-byte memory, which is organised as sixteen pages of sixteen bytes. Each instruction takes two clock cycles. In the first cycle the processor fetches the instruction byte. In the second cycle it executes that byte. The processor has one shared single-port byte memory with a combinational read path, and that memory sits outside the block. The block drives the address, the write data and the write enable, and it receives the read data in the same cycle.

Every instruction has a 4-bit operand, so the operand alone can reach only sixteen bytes. A program page register and a data page register supply the upper address nibble. A side selector picks the low or high nibble of each data byte. This gives the 4-bit datapath two independent 4-bit values per byte across all 256 bytes. Stores change only the selected nibble: the block reads the byte and writes it back with the other nibble preserved, all within the execute cycle. Debug outputs show the accumulator, the carry flag and the full program address.

Top module: `nibble_cpu`

## Requirements
- R1: After reset the accumulator is 0, carry is 0, the program address `pc_o` is 0x00, the data page is 1 with the low side selected, and the first cycle is a fetch from address 0x00.
- R2: Cycles alternate between fetch and execute. A fetch drives address {program page, counter} with write enable low, and it advances the 4-bit counter. The counter wraps from 15 to 0 without changing the page.
- R3: Opcode 0x1 loads the accumulator from the nibble at {data page, operand}. It takes bits [7:4] when the high side is selected and bits [3:0] otherwise.
- R4: Opcode 0x3 adds the selected data nibble to the accumulator, keeps the low 4 bits, and sets carry to the carry-out.
- R5: Opcode 0x2 writes the byte at {data page, operand} in its execute cycle. The selected nibble takes the accumulator value and the other nibble keeps its previous content. Write enable is never high in any other cycle.
- R6: Opcode 0x4 puts the operand in the program counter and leaves the program page unchanged.
- R7: Opcode 0x5 jumps like 0x4 when carry is 1. When carry is 0 it leaves the counter as the fetch left it.
- R8: Opcode 0x8 sets the program page to the operand and clears the counter to 0.
- R9: Opcode 0x9 sets the data page to the operand and selects the high side. Opcode 0xA sets the data page to the operand and selects the low side.
- R10: Opcodes 0x0, 0x6, 0x7 and 0xB to 0xF change no state except the fetch advance, and they never write memory. Carry changes only on opcode 0x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory byte address |
| mem_rdata_i | input | 8 | Memory read data, valid in the same cycle as the address |
| mem_wdata_o | output | 8 | Memory write data (merged byte) |
| mem_we_o | output | 1 | Memory write enable |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry flag |
| pc_o | output | 8 | Program address {program page, counter} |

## Verification
The hardest state to reach is a store to the high side, because the other nibble must survive the write. Getting there first needs a page-select instruction and a load that leaves a known accumulator value. The bench therefore runs a short program in which a store to the low side comes before a store to the high side. Each store targets a byte whose two nibbles differ, so the bench can read back the full byte afterwards. Counter wrap within a page is reached by jumping into a page filled with no-ops and then running sixteen instructions.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  localparam logic [NIB_W-1:0] OP_LDA  = 4'h1;
  localparam logic [NIB_W-1:0] OP_STA  = 4'h2;
  localparam logic [NIB_W-1:0] OP_ADD  = 4'h3;
  localparam logic [NIB_W-1:0] OP_JMP  = 4'h4;
  localparam logic [NIB_W-1:0] OP_JC   = 4'h5;
  localparam logic [NIB_W-1:0] OP_PJMP = 4'h8;
  localparam logic [NIB_W-1:0] OP_DPH  = 4'h9;
  localparam logic [NIB_W-1:0] OP_DPL  = 4'hA;

  typedef struct packed {
    logic ld;
    logic st;
    logic add;
    logic jmp;
    logic jc;
    logic pjmp;
    logic dsel;
    logic dside_hi;
  } ctrl_t;
endpackage

// File: rtl/nsc_decode.sv
module nsc_decode
  import nsc_pkg::*;
(
  input  logic [BYTE_W-1:0] instr_i,
  output ctrl_t             ctrl_o
);
  logic [NIB_W-1:0] op;
  assign op = instr_i[BYTE_W-1:NIB_W];

  always_comb begin
    ctrl_o = '0;
    unique case (op)
      OP_LDA:  ctrl_o.ld   = 1'b1;
      OP_STA:  ctrl_o.st   = 1'b1;
      OP_ADD:  ctrl_o.add  = 1'b1;
      OP_JMP:  ctrl_o.jmp  = 1'b1;
      OP_JC:   ctrl_o.jc   = 1'b1;
      OP_PJMP: ctrl_o.pjmp = 1'b1;
      OP_DPH: begin
        ctrl_o.dsel     = 1'b1;
        ctrl_o.dside_hi = 1'b1;
      end
      OP_DPL:  ctrl_o.dsel = 1'b1;
      default: ctrl_o = '0; // 0x0, 0x6, 0x7, 0xB..0xF: no-op
    endcase
  end
endmodule

// File: rtl/nsc_lane.sv
// Nibble lane: selects a nibble for reads, merges one for writes.
module nsc_lane #(
  parameter int W = 4
) (
  input  logic [2*W-1:0] byte_i,
  input  logic           side_hi_i,
  input  logic [W-1:0]   nib_i,
  output logic [W-1:0]   nib_o,
  output logic [2*W-1:0] byte_o
);
  assign nib_o  = side_hi_i ? byte_i[2*W-1:W] : byte_i[W-1:0];
  assign byte_o = side_hi_i ? {nib_i, byte_i[W-1:0]} : {byte_i[2*W-1:W], nib_i};
endmodule

// File: rtl/nsc_alu.sv
module nsc_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
  import nsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [BYTE_W-1:0] mem_addr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic [NIB_W-1:0]  acc_o,
  output logic              carry_o,
  output logic [BYTE_W-1:0] pc_o
);
  localparam logic [NIB_W-1:0] DPAGE_RST = NIB_W'(1);

  logic              exec_q;    // 0: fetch, 1: execute
  logic [BYTE_W-1:0] instr_q;
  logic [NIB_W-1:0]  pc_q, ppage_q, dpage_q, acc_q;
  logic              side_hi_q, carry_q;

  ctrl_t            ctrl;
  logic [NIB_W-1:0] opr, rd_nib, sum;
  logic             cout;

  assign opr = instr_q[NIB_W-1:0];

  nsc_decode u_dec (.instr_i(instr_q), .ctrl_o(ctrl));

  nsc_lane #(.W(NIB_W)) u_lane (
    .byte_i   (mem_rdata_i),
    .side_hi_i(side_hi_q),
    .nib_i    (acc_q),
    .nib_o    (rd_nib),
    .byte_o   (mem_wdata_o)
  );

  nsc_alu #(.W(NIB_W)) u_alu (.a_i(acc_q), .b_i(rd_nib), .sum_o(sum), .cout_o(cout));

  assign mem_addr_o = exec_q ? {dpage_q, opr} : {ppage_q, pc_q};
  assign mem_we_o   = exec_q & ctrl.st;
  assign acc_o      = acc_q;
  assign carry_o    = carry_q;
  assign pc_o       = {ppage_q, pc_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q    <= 1'b0;
      instr_q   <= '0;
      pc_q      <= '0;
      ppage_q   <= '0;
      dpage_q   <= DPAGE_RST;
      side_hi_q <= 1'b0;
      acc_q     <= '0;
      carry_q   <= 1'b0;
    end else begin
      exec_q <= ~exec_q;
      if (!exec_q) begin
        instr_q <= mem_rdata_i;
        pc_q    <= pc_q + NIB_W'(1);
      end else begin
        if (ctrl.ld) acc_q <= rd_nib;
        if (ctrl.add) begin
          acc_q   <= sum;
          carry_q <= cout;
        end
        if (ctrl.jmp || (ctrl.jc && carry_q)) pc_q <= opr;
        if (ctrl.pjmp) begin
          ppage_q <= opr;
          pc_q    <= '0;
        end
        if (ctrl.dsel) begin
          dpage_q   <= opr;
          side_hi_q <= ctrl.dside_hi;
        end
      end
    end
  end

  // R2
  fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_q |-> (!mem_we_o && mem_addr_o == pc_o));

  // R5
  we_exec_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> exec_q);

  // R5
  keep_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (side_hi_q ? mem_wdata_o[NIB_W-1:0] == mem_rdata_i[NIB_W-1:0]
                            : mem_wdata_o[BYTE_W-1:NIB_W] == mem_rdata_i[BYTE_W-1:NIB_W]));

  // R10
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_q && ctrl.add) |=> $stable(carry_o));

  // R8
  pjmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_q && ctrl.pjmp) |=> (pc_o == {$past(opr), NIB_W'(0)}));

  // R7
  jc_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_q && ctrl.jc && !carry_q) |=> $stable(pc_o));
endmodule

// File: tb/tb_nibble_cpu.sv
module tb_nibble_cpu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr, rdata, wdata;
  logic       we;
  logic [3:0] acc;
  logic       carry;
  logic [7:0] pc;
  logic [7:0] mem [256];
  int checks = 0, errors = 0, we_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nibble_cpu dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_rdata_i(rdata),
    .mem_wdata_o(wdata), .mem_we_o(we), .acc_o(acc), .carry_o(carry), .pc_o(pc)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (we) begin
    mem[addr] <= wdata;
    we_cnt <= we_cnt + 1;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic boot();
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    we_cnt = 0;
  endtask

  task automatic start();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (2 * n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    boot();
    chk("R1 acc", {4'h0, acc}, 8'h00);
    chk("R1 carry", {7'h0, carry}, 8'h00);
    chk("R1 pc", pc, 8'h00);
    chk("R1 fetch addr", addr, 8'h00);
    chk("R1 we", {7'h0, we}, 8'h00);
  endtask

  task automatic t_load_low();
    boot();
    mem[8'h00] = 8'h13; mem[8'h13] = 8'hA7;
    start();
    @(posedge clk); #1;
    chk("R2 exec addr data page 1", addr, 8'h13);
    @(posedge clk); #1;
    chk("R3 load low side", {4'h0, acc}, 8'h07);
    chk("R2 pc advance", pc, 8'h01);
  endtask

  task automatic t_load_high();
    boot();
    mem[8'h00] = 8'h91; mem[8'h01] = 8'h13; mem[8'h13] = 8'hA7;
    start(); run(2);
    chk("R3 R9 load high side", {4'h0, acc}, 8'h0A);
  endtask

  task automatic t_page_low();
    boot();
    mem[8'h00] = 8'h93; mem[8'h01] = 8'hA3; mem[8'h02] = 8'h14; mem[8'h34] = 8'h6E;
    start(); run(3);
    chk("R9 low side page 3", {4'h0, acc}, 8'h0E);
  endtask

  task automatic t_add();
    boot();
    mem[8'h00] = 8'h10; mem[8'h01] = 8'h31; mem[8'h02] = 8'h32;
    mem[8'h10] = 8'h09; mem[8'h11] = 8'h08; mem[8'h12] = 8'h01;
    start(); run(2);
    chk("R4 add overflow acc", {4'h0, acc}, 8'h01);
    chk("R4 add overflow carry", {7'h0, carry}, 8'h01);
    run(1);
    chk("R4 add no overflow acc", {4'h0, acc}, 8'h02);
    chk("R4 add clears carry", {7'h0, carry}, 8'h00);
  endtask

  task automatic t_store();
    boot();
    mem[8'h00] = 8'h10; mem[8'h01] = 8'h25; mem[8'h02] = 8'h91; mem[8'h03] = 8'h26;
    mem[8'h10] = 8'h03; mem[8'h15] = 8'h5C; mem[8'h16] = 8'h5C;
    start(); run(2);
    chk("R5 store low keeps high", mem[8'h15], 8'h53);
    run(2);
    chk("R5 store high keeps low", mem[8'h16], 8'h3C);
    chk("R5 write count", we_cnt[7:0], 8'h02);
  endtask

  task automatic t_jump();
    boot();
    mem[8'h00] = 8'h4A; mem[8'h0A] = 8'h10; mem[8'h10] = 8'h06;
    start(); run(1);
    chk("R6 jump pc", pc, 8'h0A);
    run(1);
    chk("R6 target runs", {4'h0, acc}, 8'h06);
  endtask

  task automatic t_jc(input logic take);
    boot();
    mem[8'h00] = 8'h10; mem[8'h01] = 8'h31; mem[8'h02] = 8'h58;
    mem[8'h10] = take ? 8'h0F : 8'h01; mem[8'h11] = 8'h01;
    start(); run(3);
    chk("R7 jc carry", {7'h0, carry}, {7'h0, take});
    chk("R7 jc pc", pc, take ? 8'h08 : 8'h03);
  endtask

  task automatic t_pjmp();
    boot();
    mem[8'h00] = 8'h83; mem[8'h30] = 8'h12; mem[8'h12] = 8'h09;
    start(); run(1);
    chk("R8 page jump pc", pc, 8'h30);
    run(1);
    chk("R8 fetch from new page", {4'h0, acc}, 8'h09);
    chk("R8 pc after", pc, 8'h31);
  endtask

  task automatic t_wrap();
    boot();
    mem[8'h00] = 8'h82;
    start(); run(1);
    chk("R2 wrap start", pc, 8'h20);
    run(15);
    chk("R2 before wrap", pc, 8'h2F);
    run(1);
    chk("R2 wrap in page", pc, 8'h20);
  endtask

  task automatic t_noop();
    boot();
    mem[8'h00] = 8'h10; mem[8'h01] = 8'h31;
    mem[8'h02] = 8'h00; mem[8'h03] = 8'h6F; mem[8'h04] = 8'h7F; mem[8'h05] = 8'hBF;
    mem[8'h06] = 8'hCF; mem[8'h07] = 8'hDF; mem[8'h08] = 8'hEF; mem[8'h09] = 8'hFF;
    mem[8'h0A] = 8'h12;
    mem[8'h10] = 8'h0E; mem[8'h11] = 8'h03; mem[8'h12] = 8'h05;
    start(); run(2);
    chk("R4 setup acc", {4'h0, acc}, 8'h01);
    run(8);
    chk("R10 no-op acc", {4'h0, acc}, 8'h01);
    chk("R10 no-op carry", {7'h0, carry}, 8'h01);
    chk("R10 no-op pc", pc, 8'h0A);
    chk("R10 no-op no write", we_cnt[7:0], 8'h00);
    run(1);
    chk("R10 data page kept", {4'h0, acc}, 8'h05);
    chk("R10 load keeps carry", {7'h0, carry}, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_load_low();
    t_load_high();
    t_page_low();
    t_add();
    t_store();
    t_jump();
    t_jc(1'b1);
    t_jc(1'b0);
    t_pjmp();
    t_wrap();
    t_noop();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule